// File: doc/BRIEF.md
# Speculative Instruction Fetch Front End

This block is the first stage of a two-stage processor pipeline. Once started, it presents its program counter to a combinational instruction memory port in every cycle. It captures the returned word and guesses that the following address is the current one plus the instruction size. It then pushes a record holding the fetch address, the guessed next address and the instruction word into a small decoupling queue. The execute stage pops records from the head of that queue at its own pace.

When the execute stage finds that a guess was wrong, it raises a redirect with the correct target. In that same clock edge the front end loads the target into its program counter and empties the queue. No record fetched along the wrong path can therefore reach execute. A start input loads an initial address and begins fetching, and it also acts as a restart at any later time. When the queue has no free slot, fetch stalls and the program counter holds its value.

Top module: `spec_fetch_unit`

## Requirements
- R1: After reset the queue is empty, no fetch happens and `imem_addr_o` stays at 0 until `start_i` is seen; the cycle after `start_i` is sampled high, `imem_addr_o` equals `start_pc_i`.
- R2: Every delivered record satisfies `out_ppc_o == out_pc_o + IW/8` and `out_inst_o` equals the memory word returned for address `out_pc_o`.
- R3: When `redirect_i` is high (and `start_i` low) at a clock edge, the program counter after that edge equals `redirect_pc_i`, whether fetch would otherwise have stepped or held.
- R4: When the queue holds DEPTH records and no redirect or start is present, no record is enqueued and `imem_addr_o` stays unchanged.
- R5: In the cycle after a redirect or start edge, `out_valid_o` is 0: every queued record is discarded, and `deq_i` in the redirect cycle has no further effect.
- R6: The first record delivered after a redirect has `out_pc_o` equal to the redirect target.
- R7: Without a redirect, records are delivered in fetch order with consecutive addresses spaced by IW/8, and a record stays at the head until `deq_i` is high while `out_valid_o` is high.
- R8: `start_i` takes priority over `redirect_i`, and asserting it while fetch is running flushes the queue and restarts fetch at `start_pc_i`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start_i | input | 1 | Load start address and enable fetch |
| start_pc_i | input | AW | Start address |
| redirect_i | input | 1 | Misprediction redirect from execute |
| redirect_pc_i | input | AW | Corrected target address |
| imem_addr_o | output | AW | Current program counter, to instruction memory |
| imem_data_i | input | IW | Instruction word for `imem_addr_o`, same cycle |
| deq_i | input | 1 | Execute consumes the head record |
| out_valid_o | output | 1 | Head record present |
| out_pc_o | output | AW | Head record fetch address |
| out_ppc_o | output | AW | Head record guessed next address |
| out_inst_o | output | IW | Head record instruction word |

## Verification
The bench follows the address stream that execute should see. It resets its expectation to the target on every redirect or start, and it checks that each consumed record continues that stream. A design that let a queued wrong-path record survive a flush would deliver an address other than the target. A design that gave the step priority over a redirect would show target+4 or the old address on the memory port. The bench also fills the queue and then redirects, to confirm that the load overrides the hold. It holds execute idle to show that fetch freezes the address instead of overwriting a slot. It raises start mid-stream, and it applies random redirects back-to-back with random back-pressure. In that mix, a late flush or a dropped enqueue shows up as a gap or a repeat in the order.

// File: rtl/fetch_pkg.sv
package fetch_pkg;

  typedef enum logic [1:0] {
    PC_HOLD = 2'd0,
    PC_STEP = 2'd1,
    PC_LOAD = 2'd2
  } pc_sel_e;

  function automatic pc_sel_e choose_pc_sel(input logic load, input logic step);
    if (load)      return PC_LOAD;
    else if (step) return PC_STEP;
    else           return PC_HOLD;
  endfunction

endpackage

// File: rtl/fetch_pc.sv
module fetch_pc
  import fetch_pkg::*;
#(
  parameter int AW   = 32,
  parameter int STEP = 4
) (
  input  logic          clk,
  input  logic          rst,
  input  pc_sel_e       sel_i,
  input  logic [AW-1:0] load_val_i,
  output logic [AW-1:0] pc_o
);

  localparam logic [AW-1:0] INC = AW'(STEP);

  logic [AW-1:0] pc_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      pc_q <= '0;
    end else begin
      unique case (sel_i)
        PC_LOAD: pc_q <= load_val_i;
        PC_STEP: pc_q <= pc_q + INC;
        default: pc_q <= pc_q;
      endcase
    end
  end

  assign pc_o = pc_q;

  AST_LOAD_TAKES_VALUE: assert property (@(posedge clk) disable iff (rst)
    sel_i == PC_LOAD |=> pc_o == $past(load_val_i)); // R3

  AST_HOLD_KEEPS_PC: assert property (@(posedge clk) disable iff (rst)
    sel_i == PC_HOLD |=> $stable(pc_o)); // R4

endmodule

// File: rtl/fetch_queue.sv
module fetch_queue #(
  parameter int W     = 96,
  parameter int DEPTH = 2
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         clear_i,
  input  logic         enq_i,
  input  logic [W-1:0] enq_data_i,
  input  logic         deq_i,
  output logic         valid_o,
  output logic         full_o,
  output logic [W-1:0] head_o
);

  localparam int PTRW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CNTW = $clog2(DEPTH + 1);
  localparam logic [PTRW-1:0] LAST = PTRW'(DEPTH - 1);
  localparam logic [CNTW-1:0] FULL_CNT = CNTW'(DEPTH);

  logic [W-1:0]    slot_q [DEPTH];
  logic [PTRW-1:0] wr_ptr_q, rd_ptr_q;
  logic [CNTW-1:0] count_q;

  function automatic logic [PTRW-1:0] bump(input logic [PTRW-1:0] p);
    return (p == LAST) ? '0 : p + 1'b1;
  endfunction

  // storage without reset so it maps onto RAM-style resources
  always_ff @(posedge clk) begin
    if (enq_i) slot_q[wr_ptr_q] <= enq_data_i;
  end

  always_ff @(posedge clk) begin
    if (rst || clear_i) begin
      wr_ptr_q <= '0;
      rd_ptr_q <= '0;
      count_q  <= '0;
    end else begin
      if (enq_i) wr_ptr_q <= bump(wr_ptr_q);
      if (deq_i) rd_ptr_q <= bump(rd_ptr_q);
      unique case ({enq_i, deq_i})
        2'b10:   count_q <= count_q + 1'b1;
        2'b01:   count_q <= count_q - 1'b1;
        default: count_q <= count_q;
      endcase
    end
  end

  assign valid_o = (count_q != '0);
  assign full_o  = (count_q == FULL_CNT);
  assign head_o  = slot_q[rd_ptr_q];

  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (rst)
    enq_i |-> !full_o); // R4

  AST_NO_UNDERFLOW: assert property (@(posedge clk) disable iff (rst)
    deq_i |-> valid_o); // R7

  AST_FLUSH_EMPTIES: assert property (@(posedge clk) disable iff (rst)
    clear_i |=> !valid_o); // R5

endmodule

// File: rtl/spec_fetch_unit.sv
module spec_fetch_unit
  import fetch_pkg::*;
#(
  parameter int AW    = 32,
  parameter int IW    = 32,
  parameter int DEPTH = 2
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          start_i,
  input  logic [AW-1:0] start_pc_i,
  input  logic          redirect_i,
  input  logic [AW-1:0] redirect_pc_i,
  output logic [AW-1:0] imem_addr_o,
  input  logic [IW-1:0] imem_data_i,
  input  logic          deq_i,
  output logic          out_valid_o,
  output logic [AW-1:0] out_pc_o,
  output logic [AW-1:0] out_ppc_o,
  output logic [IW-1:0] out_inst_o
);

  localparam int STEP = IW / 8;
  localparam int RECW = 2 * AW + IW;
  localparam logic [AW-1:0] INC = AW'(STEP);

  logic          running_q;
  logic          pc_load, fetch_fire, deq_fire;
  logic          q_valid, q_full;
  logic [AW-1:0] pc, load_val, guess_pc;
  logic [RECW-1:0] enq_rec, head_rec;
  pc_sel_e       pc_sel;

  // start outranks redirect; either one flushes and reloads
  assign pc_load    = start_i || redirect_i;
  assign load_val   = start_i ? start_pc_i : redirect_pc_i;
  assign fetch_fire = running_q && !q_full && !pc_load;
  assign deq_fire   = deq_i && q_valid && !pc_load;
  assign pc_sel     = choose_pc_sel(pc_load, fetch_fire);
  assign guess_pc   = pc + INC;
  assign enq_rec    = {pc, guess_pc, imem_data_i};

  always_ff @(posedge clk) begin
    if (rst)          running_q <= 1'b0;
    else if (start_i) running_q <= 1'b1;
  end

  fetch_pc #(.AW(AW), .STEP(STEP)) u_pc (
    .clk        (clk),
    .rst        (rst),
    .sel_i      (pc_sel),
    .load_val_i (load_val),
    .pc_o       (pc)
  );

  fetch_queue #(.W(RECW), .DEPTH(DEPTH)) u_queue (
    .clk        (clk),
    .rst        (rst),
    .clear_i    (pc_load),
    .enq_i      (fetch_fire),
    .enq_data_i (enq_rec),
    .deq_i      (deq_fire),
    .valid_o    (q_valid),
    .full_o     (q_full),
    .head_o     (head_rec)
  );

  assign imem_addr_o = pc;
  assign out_valid_o = q_valid;
  assign out_pc_o    = head_rec[RECW-1 -: AW];
  assign out_ppc_o   = head_rec[IW +: AW];
  assign out_inst_o  = head_rec[IW-1:0];

  AST_IDLE_BEFORE_START: assert property (@(posedge clk) disable iff (rst)
    !running_q |-> !out_valid_o); // R1

  AST_START_LOADS: assert property (@(posedge clk) disable iff (rst)
    start_i |=> imem_addr_o == $past(start_pc_i)); // R8

  AST_REDIRECT_WINS: assert property (@(posedge clk) disable iff (rst)
    redirect_i && !start_i |=> imem_addr_o == $past(redirect_pc_i)); // R3

  AST_STALL_HOLDS: assert property (@(posedge clk) disable iff (rst)
    running_q && q_full && !pc_load |=> $stable(imem_addr_o)); // R4

  AST_GUESS_STEP: assert property (@(posedge clk) disable iff (rst)
    out_valid_o |-> out_ppc_o == out_pc_o + INC); // R2

  AST_FLUSH_VISIBLE: assert property (@(posedge clk) disable iff (rst)
    pc_load |=> !out_valid_o); // R5

endmodule

// File: tb/spec_fetch_unit_tb.sv
module spec_fetch_unit_tb;

  localparam int AW = 32;
  localparam int IW = 32;
  localparam int DEPTH = 2;
  localparam logic [AW-1:0] INC = AW'(IW / 8);

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          start_i = 1'b0;
  logic [AW-1:0] start_pc_i = '0;
  logic          redirect_i = 1'b0;
  logic [AW-1:0] redirect_pc_i = '0;
  logic [AW-1:0] imem_addr_o;
  logic [IW-1:0] imem_data_i;
  logic          deq_i = 1'b0;
  logic          out_valid_o;
  logic [AW-1:0] out_pc_o, out_ppc_o;
  logic [IW-1:0] out_inst_o;

  int checks = 0;
  int errors = 0;
  int consumed = 0;

  always #5 clk = ~clk;

  function automatic logic [IW-1:0] mem_word(input logic [AW-1:0] a);
    return IW'((a * 32'h9E37_79B1) ^ 32'h1234_5678);
  endfunction

  assign imem_data_i = mem_word(imem_addr_o);

  spec_fetch_unit #(.AW(AW), .IW(IW), .DEPTH(DEPTH)) u_dut (
    .clk, .rst, .start_i, .start_pc_i, .redirect_i, .redirect_pc_i,
    .imem_addr_o, .imem_data_i, .deq_i,
    .out_valid_o, .out_pc_o, .out_ppc_o, .out_inst_o
  );

  task automatic chk(input logic ok, input string req, input logic [63:0] act,
                     input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  // scoreboard: expected address stream, reset by redirect/start
  logic [AW-1:0] exp_q[$];
  logic          after_flush = 1'b0;

  always @(negedge clk) begin
    if (!rst) begin
      if (start_i) begin
        exp_q.delete(); exp_q.push_back(start_pc_i); after_flush = 1'b1;
      end else if (redirect_i) begin
        exp_q.delete(); exp_q.push_back(redirect_pc_i); after_flush = 1'b1;
      end else if (out_valid_o && deq_i) begin
        logic [AW-1:0] e;
        e = (exp_q.size() != 0) ? exp_q.pop_front() : '1;
        if (after_flush)
          chk(out_pc_o == e, "R6 first pc after flush", 64'(out_pc_o), 64'(e));
        else
          chk(out_pc_o == e, "R7 pc order", 64'(out_pc_o), 64'(e));
        chk(out_ppc_o == e + INC, "R2 ppc", 64'(out_ppc_o), 64'(e + INC));
        chk(out_inst_o == mem_word(e), "R2 inst", 64'(out_inst_o), 64'(mem_word(e)));
        exp_q.push_back(e + INC);
        after_flush = 1'b0;
        consumed++;
      end
    end
  end

  task automatic tick();
    @(posedge clk); #1;
  endtask

  initial begin
    #(200000 * 10);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) tick();
    rst = 1'b0;
    @(negedge clk);
    chk(!out_valid_o, "R1 empty after reset", 64'(out_valid_o), 0);
    repeat (3) tick();
    @(negedge clk);
    chk(!out_valid_o && imem_addr_o == 0, "R1 idle before start", 64'(imem_addr_o), 0);

    // start, execute idle: fill and stall
    start_pc_i = 32'h100; start_i = 1'b1;
    tick(); start_i = 1'b0;
    @(negedge clk);
    chk(imem_addr_o == 32'h100, "R1 start loads pc", 64'(imem_addr_o), 64'h100);
    chk(!out_valid_o, "R1 no record yet", 64'(out_valid_o), 0);
    tick(); @(negedge clk);
    chk(out_valid_o && out_pc_o == 32'h100, "R2 first record pc", 64'(out_pc_o), 64'h100);
    chk(out_inst_o == mem_word(32'h100), "R2 first record inst", 64'(out_inst_o),
        64'(mem_word(32'h100)));
    repeat (3) tick();
    @(negedge clk);
    chk(imem_addr_o == 32'h108, "R4 stall pc", 64'(imem_addr_o), 64'h108);
    tick(); @(negedge clk);
    chk(imem_addr_o == 32'h108, "R4 pc still held", 64'(imem_addr_o), 64'h108);
    chk(out_pc_o == 32'h100, "R7 head kept without deq", 64'(out_pc_o), 64'h100);

    // drain in order
    deq_i = 1'b1;
    repeat (8) tick();

    // redirect while streaming, deq also high
    redirect_pc_i = 32'h400; redirect_i = 1'b1;
    tick(); redirect_i = 1'b0;
    @(negedge clk);
    chk(imem_addr_o == 32'h400, "R3 redirect target", 64'(imem_addr_o), 64'h400);
    chk(!out_valid_o, "R5 queue flushed", 64'(out_valid_o), 0);
    repeat (5) tick();

    // redirect while full and stalled
    deq_i = 1'b0;
    repeat (4) tick();
    redirect_pc_i = 32'h2000; redirect_i = 1'b1;
    tick(); redirect_i = 1'b0;
    @(negedge clk);
    chk(imem_addr_o == 32'h2000, "R3 redirect beats hold", 64'(imem_addr_o), 64'h2000);
    chk(!out_valid_o, "R5 full queue flushed", 64'(out_valid_o), 0);
    deq_i = 1'b1;
    repeat (4) tick();

    // start and redirect together while running: start wins
    start_pc_i = 32'h800; start_i = 1'b1;
    redirect_pc_i = 32'h3000; redirect_i = 1'b1;
    tick(); start_i = 1'b0; redirect_i = 1'b0;
    @(negedge clk);
    chk(imem_addr_o == 32'h800, "R8 restart pc", 64'(imem_addr_o), 64'h800);
    chk(!out_valid_o, "R8 restart flushes", 64'(out_valid_o), 0);
    repeat (4) tick();

    // random back-pressure and redirects
    for (int i = 0; i < 3000; i++) begin
      deq_i = ($urandom_range(0, 3) != 0);
      redirect_i = ($urandom_range(0, 11) == 0);
      redirect_pc_i = AW'($urandom_range(0, 4095)) << 2;
      tick();
    end
    redirect_i = 1'b0; deq_i = 1'b0;
    tick(); @(negedge clk);
    chk(consumed > 1000, "R7 stream progressed", 64'(consumed), 1000);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule